// File: doc/BRIEF.md
# Lamp-Bar Countdown Sequencer

This block drives a countdown on a row of lamps, one bit per lamp. A start pulse switches every lamp on, loads a step counter with the number of lamps, and arms an interval timer that expires once per second. The timer's period is `CLK_HZ` clock cycles, so it follows the clock frequency parameter.

Each time the timer expires it begins a fresh second at once. On that same cycle the lamp addressed by (count − 1) is switched off and the count drops by one. The highest lamp goes dark first and lamp 0 goes dark last. When the count reaches zero the timer stops and a done flag stays high until the next start.

A start pulse that arrives mid-countdown or after completion restarts the whole sequence. A synchronous reset returns the block to idle with everything cleared.

Top module: `lamp_countdown`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `lamps` all zero, `count` zero and `done` low, whatever `start` is doing (reset takes priority over start).
- R2: A `start` pulse sampled at a clock edge with `rst` low makes `lamps` all ones, `count` equal to `LAMPS` and `done` low from that edge on.
- R3: Before any start, the block stays idle: no lamp lights and `count` stays zero however many cycles pass.
- R4: After a start sampled at edge E0, the k-th step happens at edge E0 + k·`CLK_HZ`; `count` holds its value between steps.
- R5: At every step, lamp bit (count − 1) is cleared, so at all times bit i of `lamps` is 1 exactly when i < `count` (bit 0 is the last lamp lit).
- R6: Each step lowers `count` by exactly one; it never rises except on a start.
- R7: After the step that brings `count` to zero, `done` is high, `lamps` is zero, and both stay unchanged (no further steps) until a start or reset.
- R8: A start during an active countdown reloads all lamps and `count` = `LAMPS` and clears the timer, so the next step comes a full `CLK_HZ` cycles after that start.
- R9: A start while `done` is high clears `done` and begins a new full countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency `CLK_HZ` |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start or restart pulse |
| lamps | output | LAMPS | One bit per lamp, 1 = lit |
| count | output | $clog2(LAMPS+1) | Lamps still lit |
| done | output | 1 | High once the countdown has finished |

## Verification
A wrong timer state shows as a step that lands one or more cycles early or late. The bench catches it at the first step after start, because it samples `count` both one cycle before and exactly at each expected step edge. A wrong step count or a mis-decoded lamp index breaks the match between `lamps` and the thermometer pattern of `count` on the very step where it happens. A stuck run state shows at completion: either `done` never rises, or `count` moves past zero within one further interval.

// File: rtl/lamp_countdown_pkg.sv
package lamp_countdown_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;  // reset: all lamps off, count zero
    logic loadAll;   // start: all lamps on, count full
    logic step;      // one interval elapsed
  } lcdStrobe_t;

endpackage

// File: rtl/lamp_countdown_ctrl.sv
module lamp_countdown_ctrl
  import lamp_countdown_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       lastStep,
  output lcdStrobe_t strb,
  output logic       doneOut
);

  localparam int TW = $clog2(CLK_HZ + 1);
  localparam logic [TW-1:0] TIMER_LAST = TW'(CLK_HZ - 1);

  logic [TW-1:0] timerQ;
  logic          runningQ;
  logic          doneQ;
  logic          expire;

  assign expire = runningQ && (timerQ == TIMER_LAST);

  always_comb begin
    strb.clearAll = rst;
    strb.loadAll  = !rst && start;
    strb.step     = !rst && !start && expire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timerQ   <= '0;
      runningQ <= 1'b0;
      doneQ    <= 1'b0;
    end else if (start) begin
      timerQ   <= '0;
      runningQ <= 1'b1;
      doneQ    <= 1'b0;
    end else if (runningQ) begin
      if (expire) begin
        timerQ <= '0;
        if (lastStep) begin
          runningQ <= 1'b0;
          doneQ    <= 1'b1;
        end
      end else begin
        timerQ <= timerQ + TW'(1);
      end
    end
  end

  assign doneOut = doneQ;

endmodule

// File: rtl/lamp_countdown_dp.sv
module lamp_countdown_dp
  import lamp_countdown_pkg::*;
#(
  parameter int LAMPS = 64
) (
  input  logic                       clk,
  input  lcdStrobe_t                 strb,
  output logic [LAMPS-1:0]           lampsOut,
  output logic [$clog2(LAMPS+1)-1:0] countOut,
  output logic                       lastStep
);

  localparam int CW = $clog2(LAMPS + 1);
  localparam int IW = (LAMPS > 1) ? $clog2(LAMPS) : 1;

  logic [LAMPS-1:0] lampsQ;
  logic [CW-1:0]    countQ;
  logic [CW-1:0]    idxFull;
  logic [IW-1:0]    lampIdx;

  assign idxFull  = countQ - CW'(1);
  assign lampIdx  = idxFull[IW-1:0];
  assign lastStep = (countQ == CW'(1));

  always_ff @(posedge clk) begin
    if (strb.clearAll) begin
      lampsQ <= '0;
      countQ <= '0;
    end else if (strb.loadAll) begin
      lampsQ <= '1;
      countQ <= CW'(LAMPS);
    end else if (strb.step) begin
      lampsQ[lampIdx] <= 1'b0;
      countQ          <= idxFull;
    end
  end

  assign lampsOut = lampsQ;
  assign countOut = countQ;

endmodule

// File: rtl/lamp_countdown.sv
module lamp_countdown
  import lamp_countdown_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int LAMPS  = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  output logic [LAMPS-1:0]           lamps,
  output logic [$clog2(LAMPS+1)-1:0] count,
  output logic                       done
);

  lcdStrobe_t strb;
  logic       lastStep;

  lamp_countdown_ctrl #(.CLK_HZ(CLK_HZ)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .lastStep (lastStep),
    .strb     (strb),
    .doneOut  (done)
  );

  lamp_countdown_dp #(.LAMPS(LAMPS)) u_dp (
    .clk      (clk),
    .strb     (strb),
    .lampsOut (lamps),
    .countOut (count),
    .lastStep (lastStep)
  );

endmodule

// File: rtl/lamp_countdown_chk.sv
module lamp_countdown_chk #(
  parameter int LAMPS = 64
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       start,
  input logic [LAMPS-1:0]           lamps,
  input logic [$clog2(LAMPS+1)-1:0] count,
  input logic                       done
);

  localparam int CW = $clog2(LAMPS + 1);

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (lamps == '0 && count == '0 && !done));

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (lamps == '1 && count == CW'(LAMPS) && !done));

  // R5
  lamp_count_match_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(lamps) == int'(count)));

  // R6
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && count != '0) |=> (count == $past(count) || count == $past(count) - CW'(1)));

  // R7
  done_empty_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (lamps == '0 && count == '0));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(count)));

endmodule

bind lamp_countdown lamp_countdown_chk #(.LAMPS(LAMPS)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .lamps (lamps),
  .count (count),
  .done  (done)
);

// File: tb/lamp_countdown_tb.sv
`timescale 1ns/1ps
module lamp_countdown_tb;

  localparam int HZ = 5;
  localparam int N  = 64;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [N-1:0]  lamps;
  logic [CW-1:0] count;
  logic          done;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lamp_countdown #(.CLK_HZ(HZ), .LAMPS(N)) u_dut (
    .clk(clk), .rst(rst), .start(start),
    .lamps(lamps), .count(count), .done(done)
  );

  function automatic logic [N-1:0] thermo(int k);
    logic [N:0] one = 1;
    logic [N:0] v = (one << k) - 1;
    return v[N-1:0];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitN(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic checkState(string req, int k, bit expDone);
    chk({req, " count"}, 64'(count), 64'(k));
    chk({req, " lamps"}, 64'(lamps), 64'(thermo(k)));
    chk({req, " done"}, 64'(done), 64'(expDone));
  endtask

  task automatic testReset();
    rst = 1'b1;
    waitN(2);
    rst = 1'b0;
    checkState("R1 reset", 0, 0);
  endtask

  task automatic testIdle();
    waitN(3 * HZ);
    checkState("R3 idle", 0, 0);
  endtask

  task automatic testFullRun();
    pulseStart();
    checkState("R2 start", N, 0);
    for (int k = 1; k <= N; k++) begin
      waitN(HZ - 1);
      chk("R4 hold before step", 64'(count), 64'(N - k + 1));
      waitN(1);
      chk("R6 step count", 64'(count), 64'(N - k));
      chk("R5 lamp pattern", 64'(lamps), 64'(thermo(N - k)));
    end
    chk("R7 done", 64'(done), 64'd1);
    waitN(3 * HZ);
    checkState("R7 held", 0, 1);
  endtask

  task automatic testRestartMid();
    pulseStart();
    waitN(10 * HZ + 2);
    chk("R8 pre-restart", 64'(count), 64'(N - 10));
    pulseStart();
    checkState("R8 restart", N, 0);
    waitN(HZ - 1);
    chk("R8 timer cleared", 64'(count), 64'(N));
    waitN(1);
    chk("R8 first step", 64'(count), 64'(N - 1));
    chk("R8 lamps", 64'(lamps), 64'(thermo(N - 1)));
  endtask

  task automatic testResetMid();
    waitN(3 * HZ);
    @(negedge clk) begin rst = 1'b1; start = 1'b1; end
    @(negedge clk) begin rst = 1'b0; start = 1'b0; end
    checkState("R1 reset over start", 0, 0);
    waitN(2 * HZ);
    checkState("R3 idle after reset", 0, 0);
  endtask

  initial begin
    testReset();
    testIdle();
    testFullRun();
    // R9: start from done
    testFullRun();
    testRestartMid();
    testResetMid();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule